// File: doc/BRIEF.md
# Interrupt Destination Match Logic

This block decides which of a set of processor-local interrupt units accept an interrupt sent by one unit to others, or arriving as a message. A sender programs a two-word command: the high word only stores the target byte, and a write of the low word launches the send. Message requests arrive on a separate set of ports carrying the target byte, addressing mode, delivery mode, vector and trigger bit. The block checks every present unit against the target, whether by physical ID, by flat logical bitmap or by cluster logical addressing. It then applies the sender-relative shorthands. Its result is an accept mask for the units, together with the vector, delivery mode and trigger bit that travel with it.

For lowest-priority delivery the mask is cut down to the single lowest-indexed accepting unit. An INIT command sent with level 0 and trigger 1 carries no interrupt. It raises a separate pulse, along with the target mask, that tells each listed unit to copy its physical ID into its arbitration ID.

The control is a two-state machine. ST_IDLE means no request is held. ST_EVAL means a request captured on the previous edge is being resolved into the registered outputs. The machine moves from ST_IDLE to ST_EVAL when a request fires. It stays in ST_EVAL when another request fires in the same cycle, and it returns from ST_EVAL to ST_IDLE when none does. A request therefore costs one cycle, and one request can be taken every cycle.

Top module: `irq_dest_router`

## Requirements
- R1: With the addressing bit 0 (physical), target byte 0xFF accepts every present unit. Any other target accepts each present unit whose physical ID equals the target byte.
- R2: With the addressing bit 1 (logical), a unit whose format nibble is 0xF accepts when the target byte ANDed with its logical byte is nonzero.
- R3: With the addressing bit 1, a unit whose format nibble is 0x0 accepts when the upper nibble of the target equals the upper nibble of its logical byte and the lower nibbles AND to a nonzero value. A unit with any other format nibble never accepts a logical target.
- R4: Low command word fields are vector [7:0], delivery mode [10:8], addressing bit [11], level [14], trigger [15] and shorthand [19:18]. The target byte is bits [31:24] of the high command word. Writing the high word stores that byte and produces no output. Writing the low word sends using the stored byte.
- R5: Shorthand 0 uses the target byte. Shorthand 1 accepts only the sender unit given by `sender_idx`. Shorthand 2 accepts all present units. Shorthand 3 accepts all present units except the sender. For shorthands 1 to 3 the target byte is ignored.
- R6: Delivery mode 1 (lowest priority) reduces the mask to its lowest-indexed set bit, or to zero if the mask is empty.
- R7: A command with delivery mode 5 and level 0 and trigger 1 raises `sync_valid` with the target mask in `sync_mask` and does not raise `dlv_valid`. Mode 5 with any other level or trigger is delivered normally.
- R8: A unit whose `unit_present` bit is 0 never appears in either mask.
- R9: A message request uses shorthand 0 and never takes the R7 path. When a command low write and a message fire in the same cycle, the command is served and the message is dropped.
- R10: After reset both valid outputs are 0. The result of a request sampled on a rising edge appears after the second rising edge that follows, with the valid high for one cycle. A request on every cycle gives a result on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_lo_we | input | 1 | Write strobe for the low command word; launches a send |
| cmd_hi_we | input | 1 | Write strobe for the high command word; stores the target byte |
| cmd_wdata | input | 32 | Command write data |
| msg_valid | input | 1 | Message request strobe |
| msg_dest | input | 8 | Message target byte |
| msg_logical | input | 1 | Message addressing bit (1 = logical) |
| msg_mode | input | 3 | Message delivery mode |
| msg_vector | input | 8 | Message vector |
| msg_trigger | input | 1 | Message trigger bit |
| sender_idx | input | IDX_W | Index of the unit issuing commands |
| unit_present | input | NUM_UNITS | Presence bit per unit |
| unit_phys_id | input | 8*NUM_UNITS | Physical ID per unit, unit i at [8i+7:8i] |
| unit_log_dest | input | 8*NUM_UNITS | Logical byte per unit |
| unit_fmt | input | 4*NUM_UNITS | Format nibble per unit |
| dlv_valid | output | 1 | Delivery result valid (one cycle) |
| dlv_mask | output | NUM_UNITS | Accepting units |
| dlv_vector | output | 8 | Vector of the delivery |
| dlv_mode | output | 3 | Delivery mode of the delivery |
| dlv_trigger | output | 1 | Trigger bit of the delivery |
| sync_valid | output | 1 | Arbitration-ID copy request valid (one cycle) |
| sync_mask | output | NUM_UNITS | Units that copy their physical ID into their arbitration ID |

## Verification
A fixed population mixes flat units with one-hot logical bytes and cluster units that share or differ in upper nibble, and leaves one unit absent. Physical targets are tried as a unique hit, a miss, the broadcast byte and the absent unit's ID, which separates an ID compare from a broadcast and from the presence filter. Logical targets hit flat-only, cluster-only and mixed sets, so a wrong nibble split or a wrong format decode shows up as a different mask. Shorthands are sent with a stored target that would select another unit. The three level and trigger combinations of INIT, lowest priority on multi-hit and empty masks, and a command colliding with a message pin down the special paths.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int DEST_W = 8;
    localparam int FMT_W  = 4;
    localparam int VEC_W  = 8;

    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;
    localparam logic [DEST_W-1:0] DEST_BCAST = 8'hFF;

    typedef enum logic [2:0] {
        DM_FIXED    = 3'd0,
        DM_LOWEST   = 3'd1,
        DM_SMI      = 3'd2,
        DM_RSV3     = 3'd3,
        DM_NMI      = 3'd4,
        DM_INIT     = 3'd5,
        DM_STARTUP  = 3'd6,
        DM_EXTERNAL = 3'd7
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_TARGET = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              logical;
        shorthand_e        sh;
        dlv_mode_e         mode;
        logic [VEC_W-1:0]  vector;
        logic              trigger;
        logic              level;
        logic              from_cmd;
    } route_req_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_route_pkg::*;
(
    input  logic [31:0]       lo_word,
    input  logic [DEST_W-1:0] dest_byte,
    output route_req_t        req
);
    logic unused_bits;
    assign unused_bits = ^{lo_word[31:20], lo_word[17:16], lo_word[13:12]};

    always_comb begin
        req.dest     = dest_byte;
        req.vector   = lo_word[7:0];
        req.mode     = dlv_mode_e'(lo_word[10:8]);
        req.logical  = lo_word[11];
        req.level    = lo_word[14];
        req.trigger  = lo_word[15];
        req.sh       = shorthand_e'(lo_word[19:18]);
        req.from_cmd = 1'b1;
    end
endmodule

// File: rtl/irq_unit_match.sv
module irq_unit_match
    import irq_route_pkg::*;
(
    input  route_req_t        req,
    input  logic              is_sender,
    input  logic              present,
    input  logic [DEST_W-1:0] phys_id,
    input  logic [DEST_W-1:0] log_dest,
    input  logic [FMT_W-1:0]  fmt,
    output logic              hit
);
    localparam int HALF = DEST_W / 2;

    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic addr_hit;
    logic sel_hit;

    always_comb begin
        phys_hit = (req.dest == DEST_BCAST) || (req.dest == phys_id);
        flat_hit = (fmt == FMT_FLAT) && (|(req.dest & log_dest));
        clus_hit = (fmt == FMT_CLUSTER)
                   && (req.dest[DEST_W-1:HALF] == log_dest[DEST_W-1:HALF])
                   && (|(req.dest[HALF-1:0] & log_dest[HALF-1:0]));
        addr_hit = req.logical ? (flat_hit || clus_hit) : phys_hit;
        unique case (req.sh)
            SH_TARGET: sel_hit = addr_hit;
            SH_SELF:   sel_hit = is_sender;
            SH_ALL:    sel_hit = 1'b1;
            SH_OTHERS: sel_hit = !is_sender;
            default:   sel_hit = 1'b0;
        endcase
        hit = present && sel_hit;
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_mask,
    output logic [W-1:0] out_mask
);
    always_comb begin
        out_mask = in_mask & (~in_mask + W'(1));
    end
endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
    import irq_route_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_lo_we,
    input  logic                        cmd_hi_we,
    input  logic [31:0]                 cmd_wdata,
    input  logic                        msg_valid,
    input  logic [7:0]                  msg_dest,
    input  logic                        msg_logical,
    input  logic [2:0]                  msg_mode,
    input  logic [7:0]                  msg_vector,
    input  logic                        msg_trigger,
    input  logic [IDX_W-1:0]            sender_idx,
    input  logic [NUM_UNITS-1:0]        unit_present,
    input  logic [8*NUM_UNITS-1:0]      unit_phys_id,
    input  logic [8*NUM_UNITS-1:0]      unit_log_dest,
    input  logic [4*NUM_UNITS-1:0]      unit_fmt,
    output logic                        dlv_valid,
    output logic [NUM_UNITS-1:0]        dlv_mask,
    output logic [7:0]                  dlv_vector,
    output logic [2:0]                  dlv_mode,
    output logic                        dlv_trigger,
    output logic                        sync_valid,
    output logic [NUM_UNITS-1:0]        sync_mask
);
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } st_e;

    st_e               state_q, state_d;
    logic [DEST_W-1:0] dest_hi_q;
    route_req_t        cmd_req, msg_req, req_d, req_q;
    logic              req_fire;
    logic [NUM_UNITS-1:0] hit_vec;
    logic [NUM_UNITS-1:0] low_vec;
    logic              init_deassert;

    // stored target byte from the high command word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_hi_q <= '0;
        end else if (cmd_hi_we) begin
            dest_hi_q <= cmd_wdata[31:24];
        end
    end

    irq_cmd_decode u_decode (
        .lo_word   (cmd_wdata),
        .dest_byte (dest_hi_q),
        .req       (cmd_req)
    );

    always_comb begin
        msg_req.dest     = msg_dest;
        msg_req.logical  = msg_logical;
        msg_req.sh       = SH_TARGET;
        msg_req.mode     = dlv_mode_e'(msg_mode);
        msg_req.vector   = msg_vector;
        msg_req.trigger  = msg_trigger;
        msg_req.level    = 1'b1;
        msg_req.from_cmd = 1'b0;
        req_fire = cmd_lo_we || msg_valid;
        req_d    = cmd_lo_we ? cmd_req : msg_req;
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_fire ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = req_fire ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (req_fire) begin
            req_q <= req_d;
        end
    end

    for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
        irq_unit_match u_match (
            .req       (req_q),
            .is_sender (sender_idx == IDX_W'(gi)),
            .present   (unit_present[gi]),
            .phys_id   (unit_phys_id[gi*8 +: 8]),
            .log_dest  (unit_log_dest[gi*8 +: 8]),
            .fmt       (unit_fmt[gi*4 +: 4]),
            .hit       (hit_vec[gi])
        );
    end

    irq_lowest_pick #(.W(NUM_UNITS)) u_lowest (
        .in_mask  (hit_vec),
        .out_mask (low_vec)
    );

    assign init_deassert = req_q.from_cmd && (req_q.mode == DM_INIT)
                           && !req_q.level && req_q.trigger;

    // output register, loaded while a request is being resolved
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_valid   <= 1'b0;
            dlv_mask    <= '0;
            dlv_vector  <= '0;
            dlv_mode    <= '0;
            dlv_trigger <= 1'b0;
            sync_valid  <= 1'b0;
            sync_mask   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    dlv_valid  <= 1'b0;
                    sync_valid <= 1'b0;
                end
                ST_EVAL: begin
                    if (init_deassert) begin
                        dlv_valid  <= 1'b0;
                        sync_valid <= 1'b1;
                        sync_mask  <= hit_vec;
                    end else begin
                        sync_valid  <= 1'b0;
                        dlv_valid   <= 1'b1;
                        dlv_mask    <= (req_q.mode == DM_LOWEST) ? low_vec : hit_vec;
                        dlv_vector  <= req_q.vector;
                        dlv_mode    <= req_q.mode;
                        dlv_trigger <= req_q.trigger;
                    end
                end
                default: begin
                    dlv_valid  <= 1'b0;
                    sync_valid <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_dest_router_chk.sv
module irq_dest_router_chk #(
    parameter int NUM_UNITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_lo_we,
    input logic                 msg_valid,
    input logic [NUM_UNITS-1:0] unit_present,
    input logic                 dlv_valid,
    input logic [NUM_UNITS-1:0] dlv_mask,
    input logic [2:0]           dlv_mode,
    input logic                 sync_valid,
    input logic [NUM_UNITS-1:0] sync_mask
);
    // R6: lowest-priority result names at most one unit
    assert_lowest_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 3'd1) |-> $onehot0(dlv_mask));

    // R8: absent units never accept
    assert_present_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid || sync_valid) |->
            (((dlv_valid ? dlv_mask : '0) | (sync_valid ? sync_mask : '0))
             & ~$past(unit_present)) == '0);

    // R7: a result is either a delivery or a sync, never both
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dlv_valid && sync_valid));

    // R7: a sync only follows a command write
    assert_sync_from_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |-> $past(cmd_lo_we, 2));

    // R10: every request yields a result two edges later
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lo_we || msg_valid) |-> ##2 (dlv_valid || sync_valid));

    // R4: without a request there is no result (a high write alone is silent)
    assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cmd_lo_we, 2) && !$past(msg_valid, 2)) |-> (!dlv_valid && !sync_valid));
endmodule

bind irq_dest_router irq_dest_router_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_lo_we    (cmd_lo_we),
    .msg_valid    (msg_valid),
    .unit_present (unit_present),
    .dlv_valid    (dlv_valid),
    .dlv_mask     (dlv_mask),
    .dlv_mode     (dlv_mode),
    .sync_valid   (sync_valid),
    .sync_mask    (sync_mask)
);

// File: tb/irq_dest_router_test.sv
`timescale 1ns/1ps
module irq_dest_router_test;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_lo_we = 1'b0, cmd_hi_we = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic          msg_valid = 1'b0, msg_logical = 1'b0, msg_trigger = 1'b0;
    logic [7:0]    msg_dest = '0, msg_vector = '0;
    logic [2:0]    msg_mode = '0;
    logic [IW-1:0] sender_idx = 3'd2;
    logic [N-1:0]  unit_present = 8'b0111_1111;
    logic [8*N-1:0] unit_phys_id;
    logic [8*N-1:0] unit_log_dest;
    logic [4*N-1:0] unit_fmt;
    logic          dlv_valid, dlv_trigger, sync_valid;
    logic [N-1:0]  dlv_mask, sync_mask;
    logic [7:0]    dlv_vector;
    logic [2:0]    dlv_mode;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // units 0..3 flat, one-hot logical bytes; 4..7 cluster; unit 7 absent
    assign unit_phys_id  = {8'h17, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
    assign unit_log_dest = {8'h21, 8'h31, 8'h22, 8'h21, 8'h08, 8'h04, 8'h02, 8'h01};
    assign unit_fmt      = {4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};

    irq_dest_router #(.NUM_UNITS(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_lo_we(cmd_lo_we), .cmd_hi_we(cmd_hi_we),
        .cmd_wdata(cmd_wdata), .msg_valid(msg_valid), .msg_dest(msg_dest),
        .msg_logical(msg_logical), .msg_mode(msg_mode), .msg_vector(msg_vector),
        .msg_trigger(msg_trigger), .sender_idx(sender_idx), .unit_present(unit_present),
        .unit_phys_id(unit_phys_id), .unit_log_dest(unit_log_dest), .unit_fmt(unit_fmt),
        .dlv_valid(dlv_valid), .dlv_mask(dlv_mask), .dlv_vector(dlv_vector),
        .dlv_mode(dlv_mode), .dlv_trigger(dlv_trigger), .sync_valid(sync_valid),
        .sync_mask(sync_mask)
    );

    // {low word, stored target, expected mask, sync expected, requirement number}
    localparam int NV = 16;
    localparam logic [56:0] TBL [NV] = '{
        {32'h0000_0040, 8'h13, 8'h08, 1'b0, 8'd1},  // R1 physical unique hit
        {32'h0000_0041, 8'hFF, 8'h7F, 1'b0, 8'd1},  // R1 broadcast byte
        {32'h0000_0042, 8'h17, 8'h00, 1'b0, 8'd8},  // R8 ID of absent unit
        {32'h0000_0043, 8'h55, 8'h00, 1'b0, 8'd1},  // R1 no match
        {32'h0000_0844, 8'h05, 8'h05, 1'b0, 8'd2},  // R2 flat two hits
        {32'h0000_8845, 8'h21, 8'h11, 1'b0, 8'd3},  // R3 cluster + flat, trigger 1
        {32'h0000_0846, 8'h33, 8'h43, 1'b0, 8'd3},  // R3 other cluster
        {32'h0004_0050, 8'h13, 8'h04, 1'b0, 8'd5},  // R5 self, target ignored
        {32'h0008_0051, 8'h13, 8'h7F, 1'b0, 8'd5},  // R5 all
        {32'h000C_0052, 8'h13, 8'h7B, 1'b0, 8'd5},  // R5 all but sender
        {32'h0000_0960, 8'h06, 8'h02, 1'b0, 8'd6},  // R6 lowest of two
        {32'h000C_0161, 8'h00, 8'h01, 1'b0, 8'd6},  // R6 lowest of others
        {32'h0000_0162, 8'h55, 8'h00, 1'b0, 8'd6},  // R6 empty stays empty
        {32'h0008_8500, 8'h00, 8'h7F, 1'b1, 8'd7},  // R7 level 0 trigger 1: sync
        {32'h0008_C500, 8'h00, 8'h7F, 1'b0, 8'd7},  // R7 level 1: delivered
        {32'h0000_0500, 8'h10, 8'h01, 1'b0, 8'd7}   // R7 trigger 0: delivered
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_hi(input logic [7:0] d);
        cmd_hi_we = 1'b1;
        cmd_wdata = {d, 24'h5A5A5A};
        @(negedge clk);
        cmd_hi_we = 1'b0;
    endtask

    // drive the low word, return at the negedge where the result is visible
    task automatic wr_lo(input logic [31:0] w);
        cmd_lo_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_lo_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset valids", {62'd0, dlv_valid, sync_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] lo;
            logic [7:0]  dst, em, rq;
            logic        es;
            {lo, dst, em, es, rq} = TBL[i];
            wr_hi(dst);
            wr_lo(lo);
            if (es) begin
                chk($sformatf("R%0d row %0d sync", rq, i),
                    {54'd0, dlv_valid, sync_valid, sync_mask}, {54'd0, 1'b0, 1'b1, em});
            end else begin
                chk($sformatf("R%0d row %0d mask", rq, i),
                    {54'd0, dlv_valid, sync_valid, dlv_mask}, {54'd0, 1'b1, 1'b0, em});
                chk($sformatf("R4 row %0d fields", i),
                    {52'd0, dlv_vector, dlv_mode, dlv_trigger},
                    {52'd0, lo[7:0], lo[10:8], lo[15]});
            end
        end

        // R10 valid lasts one cycle
        @(negedge clk);
        chk("R10 single-cycle valid", {62'd0, dlv_valid, sync_valid}, 64'd0);

        // R4 high write alone is silent, and its low bits do not matter
        wr_hi(8'h12);
        @(negedge clk);
        chk("R4 high write silent", {62'd0, dlv_valid, sync_valid}, 64'd0);
        @(negedge clk);
        chk("R4 high write silent later", {62'd0, dlv_valid, sync_valid}, 64'd0);
        wr_lo(32'h0000_0070);
        chk("R4 stored target used", {55'd0, dlv_valid, dlv_mask}, {55'd0, 1'b1, 8'h04});
        wr_lo(32'h0000_0071);
        chk("R4 stored target reused", {55'd0, dlv_valid, dlv_mask}, {55'd0, 1'b1, 8'h04});

        // R9 message request, logical cluster target
        msg_valid = 1'b1; msg_dest = 8'h21; msg_logical = 1'b1;
        msg_mode = 3'd0; msg_vector = 8'h77; msg_trigger = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        @(negedge clk);
        chk("R9 message mask", {55'd0, dlv_valid, dlv_mask}, {55'd0, 1'b1, 8'h11});
        chk("R9 message fields", {52'd0, dlv_vector, dlv_mode, dlv_trigger},
            {52'd0, 8'h77, 3'd0, 1'b1});

        // R9 message INIT with trigger 1 is delivered, not synced
        msg_valid = 1'b1; msg_dest = 8'h10; msg_logical = 1'b0;
        msg_mode = 3'd5; msg_vector = 8'h00; msg_trigger = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        @(negedge clk);
        chk("R9 message INIT delivered", {54'd0, dlv_valid, sync_valid, dlv_mask},
            {54'd0, 1'b1, 1'b0, 8'h01});

        // R9 command and message together: command wins, message dropped
        msg_valid = 1'b1; msg_dest = 8'hFF; msg_vector = 8'h99; msg_mode = 3'd0;
        cmd_lo_we = 1'b1; cmd_wdata = 32'h0004_0033;
        @(negedge clk);
        msg_valid = 1'b0; cmd_lo_we = 1'b0;
        @(negedge clk);
        chk("R9 command wins", {47'd0, dlv_valid, dlv_mask, dlv_vector},
            {47'd0, 1'b1, 8'h04, 8'h33});
        @(negedge clk);
        chk("R9 message dropped", {62'd0, dlv_valid, sync_valid}, 64'd0);

        // R10 back-to-back requests give back-to-back results
        cmd_lo_we = 1'b1; cmd_wdata = 32'h0004_0081;
        @(negedge clk);
        cmd_wdata = 32'h0008_0082;
        @(negedge clk);
        cmd_lo_we = 1'b0;
        chk("R10 first of pair", {47'd0, dlv_valid, dlv_mask, dlv_vector},
            {47'd0, 1'b1, 8'h04, 8'h81});
        @(negedge clk);
        chk("R10 second of pair", {47'd0, dlv_valid, dlv_mask, dlv_vector},
            {47'd0, 1'b1, 8'h7F, 8'h82});

        // R8 presence change takes effect
        unit_present = 8'b0111_1110;
        wr_lo(32'h0008_0090);
        chk("R8 removed unit excluded", {55'd0, dlv_valid, dlv_mask}, {55'd0, 1'b1, 8'h7E});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule